// File: doc/BRIEF.md
# MSI Doorbell Event Queue Controller

The controller accepts message-signalled interrupt writes that land in a doorbell page and appends each one to a circular ring of 32-bit entries in host memory. A configurable number of independent queues is supported. Each queue has its own 4 KB ring page, its own 4 KB doorbell page, a control word, a hardware-advanced tail and a software-advanced head. The controller does not interpret the doorbell data. Any 16-bit value is queued, so one wired interrupt can stand for many distinct message vectors.

Software reads the tail and drains entries one at a time by writing the next head value. Each queue has a level interrupt output that stays high while its ring holds unread entries and all of its enables are set. When a ring is full, a new doorbell write is discarded and a sticky overflow flag is raised. The block emits one memory write request at a time. While that request is outstanding it refuses further doorbells.

Top module: `msi_evq_ctrl`

## Requirements
- R1: A doorbell write hits queue q when queue q is enabled (control bit 0) and bits 63:12 of the doorbell address equal queue q's doorbell page. When several queues hit, the lowest index wins. A hit issues a memory write at ring page + tail×4. Its data is the 16-bit doorbell value in bits 15:0 with bits 31:16 zero, whatever that value is.
- R2: The tail of a queue advances by one, modulo 64, only when its memory request is accepted (mem_valid and mem_ready both high). A stalled request keeps the same address and data. db_ready is low while a request is outstanding, and a doorbell offered then is ignored.
- R3: A ring is full when tail+1 equals head, modulo 64. A hit on a full ring issues no request and leaves the tail unchanged. It sets the overflow flag (status bit 0), which stays set until software writes 1 to status bit 0.
- R4: irq[q] is high exactly when control bits 0 (queue enable), 1 (interrupt on event) and 11 (interrupt enable) are all set, global-enable bit q is set, and head differs from tail.
- R5: Software sets the head by writing bits 5:0 of the head register. irq[q] falls in the cycle after the head is made equal to the tail.
- R6: A doorbell write that matches no enabled queue's page creates no request and changes no tail. This includes a write to a disabled queue's page.
- R7: Each page is programmed as a low word and a high word. The low word holds address bits 31:12 and reads back with bits 11:0 zero. The high word holds bits 63:32.
- R8: The register word address for queue q is q×8 + k. The values of k are: 0 ring low, 1 ring high, 2 doorbell low, 3 doorbell high, 4 control, 5 head, 6 tail (read-only), 7 status. Word NQ×8 is the global enable register, with one bit per queue. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| db_valid | input | 1 | Doorbell write present |
| db_addr | input | 64 | Doorbell write address |
| db_data | input | 16 | Doorbell message data |
| db_ready | output | 1 | Doorbell can be taken this cycle |
| mem_valid | output | 1 | Ring entry write request |
| mem_addr | output | 64 | Ring entry byte address |
| mem_data | output | 32 | Ring entry word |
| mem_ready | input | 1 | Memory accepts the request |
| irq | output | NQ | Per-queue level interrupt |

## Verification
The bench builds the block with two queues, a 64-entry ring and the global enable register present. With two queues the bench can check doorbell page selection, and show that a disabled queue does not take a doorbell that then falls through to the other queue. The 64-entry ring is short enough for the bench to fill a ring completely, observe the drop and overflow, and then wrap the tail from 63 back to 0. Along the way every irq gate is opened and closed one at a time.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int PAGE_LSB     = 12;
    localparam int CTL_QEN_BIT  = 0;
    localparam int CTL_EVT_BIT  = 1;
    localparam int CTL_IEN_BIT  = 11;

    typedef enum logic [2:0] {
        W_RING_LO = 3'd0,
        W_RING_HI = 3'd1,
        W_BELL_LO = 3'd2,
        W_BELL_HI = 3'd3,
        W_CTRL    = 3'd4,
        W_HEAD    = 3'd5,
        W_TAIL    = 3'd6,
        W_STAT    = 3'd7
    } qword_e;
endpackage

// File: rtl/evq_slot.sv
module evq_slot
    import evq_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        word,
    input  logic [31:0]       wdata,
    input  logic              gate_en,
    input  logic              push,
    input  logic              drop,
    output logic [51:0]       ring_pg,
    output logic [51:0]       bell_pg,
    output logic              qen,
    output logic              full,
    output logic [PTR_W-1:0]  tail,
    output logic [31:0]       rd_word,
    output logic              irq
);
    typedef struct packed {
        logic [51:0]      ring;
        logic [51:0]      bell;
        logic             qen;
        logic             evt;
        logic             ien;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic             ovf;
    } slot_t;

    slot_t s_d, s_q;
    logic  unused_wbits;
    assign unused_wbits = ^wdata;

    always_comb begin
        s_d = s_q;
        if (push) s_d.tail = PTR_W'(s_q.tail + PTR_W'(1));
        if (wr_en) begin
            case (qword_e'(word))
                W_RING_LO: s_d.ring[19:0]  = wdata[31:12];
                W_RING_HI: s_d.ring[51:20] = wdata;
                W_BELL_LO: s_d.bell[19:0]  = wdata[31:12];
                W_BELL_HI: s_d.bell[51:20] = wdata;
                W_CTRL: begin
                    s_d.qen = wdata[CTL_QEN_BIT];
                    s_d.evt = wdata[CTL_EVT_BIT];
                    s_d.ien = wdata[CTL_IEN_BIT];
                end
                W_HEAD: s_d.head = wdata[PTR_W-1:0];
                W_STAT: if (wdata[0]) s_d.ovf = 1'b0;
                default: ;
            endcase
        end
        if (drop) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_word = '0;
        case (qword_e'(word))
            W_RING_LO: rd_word = {s_q.ring[19:0], 12'h000};
            W_RING_HI: rd_word = s_q.ring[51:20];
            W_BELL_LO: rd_word = {s_q.bell[19:0], 12'h000};
            W_BELL_HI: rd_word = s_q.bell[51:20];
            W_CTRL: begin
                rd_word[CTL_QEN_BIT] = s_q.qen;
                rd_word[CTL_EVT_BIT] = s_q.evt;
                rd_word[CTL_IEN_BIT] = s_q.ien;
            end
            W_HEAD: rd_word = 32'(s_q.head);
            W_TAIL: rd_word = 32'(s_q.tail);
            W_STAT: rd_word = {31'h0, s_q.ovf};
            default: ;
        endcase
    end

    assign ring_pg = s_q.ring;
    assign bell_pg = s_q.bell;
    assign qen     = s_q.qen;
    assign tail    = s_q.tail;
    assign full    = PTR_W'(s_q.tail + PTR_W'(1)) == s_q.head;
    assign irq     = s_q.qen & s_q.evt & s_q.ien & gate_en & (s_q.head != s_q.tail);
endmodule

// File: rtl/evq_stage.sv
module evq_stage #(
    parameter int QW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [63:0]   load_addr,
    input  logic [31:0]   load_data,
    input  logic [QW-1:0] load_q,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic [63:0]   mem_addr,
    output logic [31:0]   mem_data,
    output logic          done,
    output logic [QW-1:0] done_q
);
    typedef struct packed {
        logic          valid;
        logic [63:0]   addr;
        logic [31:0]   data;
        logic [QW-1:0] qi;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && mem_ready) st_d.valid = 1'b0;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.addr  = load_addr;
            st_d.data  = load_data;
            st_d.qi    = load_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_valid = st_q.valid;
    assign mem_addr  = st_q.addr;
    assign mem_data  = st_q.data;
    assign done      = st_q.valid & mem_ready;
    assign done_q    = st_q.qi;
endmodule

// File: rtl/msi_evq_ctrl.sv
module msi_evq_ctrl
    import evq_pkg::*;
#(
    parameter int  NQ            = 4,
    parameter int  PTR_W         = 6,
    parameter bit  HAS_GLOBAL_EN = 1'b1,
    localparam int RAW           = $clog2(NQ * 8 + 1),
    localparam int QW            = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            db_valid,
    input  logic [63:0]     db_addr,
    input  logic [15:0]     db_data,
    output logic            db_ready,
    output logic            mem_valid,
    output logic [63:0]     mem_addr,
    output logic [31:0]     mem_data,
    input  logic            mem_ready,
    output logic [NQ-1:0]   irq
);
    logic [51:0]      ring_pg  [NQ];
    logic [51:0]      bell_pg  [NQ];
    logic [PTR_W-1:0] tail_arr [NQ];
    logic [31:0]      rd_word  [NQ];
    logic [NQ-1:0]    qen, full, push, drop, slot_wr, gen_en;
    logic             done, load, any_hit;
    logic [QW-1:0]    done_q, sel;
    logic [63:0]      load_addr;
    logic             unused_db;
    assign unused_db = ^db_addr[PAGE_LSB-1:0];

    localparam logic [RAW-1:0] GEN_ADDR = RAW'(NQ * 8);

    for (genvar g = 0; g < NQ; g++) begin : g_slot
        assign slot_wr[g] = reg_wr && (int'(reg_addr[RAW-1:3]) == g);
        assign push[g]    = done && (done_q == QW'(g));
        evq_slot #(.PTR_W(PTR_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (slot_wr[g]),
            .word    (reg_addr[2:0]),
            .wdata   (reg_wdata),
            .gate_en (gen_en[g]),
            .push    (push[g]),
            .drop    (drop[g]),
            .ring_pg (ring_pg[g]),
            .bell_pg (bell_pg[g]),
            .qen     (qen[g]),
            .full    (full[g]),
            .tail    (tail_arr[g]),
            .rd_word (rd_word[g]),
            .irq     (irq[g])
        );
    end

    if (HAS_GLOBAL_EN) begin : g_gen
        logic [NQ-1:0] gen_d, gen_q;
        always_comb begin
            gen_d = gen_q;
            if (reg_wr && reg_addr == GEN_ADDR) gen_d = reg_wdata[NQ-1:0];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) gen_q <= '0;
            else        gen_q <= gen_d;
        end
        assign gen_en = gen_q;
    end else begin : g_nogen
        assign gen_en = '1;
    end

    // doorbell page match, lowest queue index wins
    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int q = NQ - 1; q >= 0; q--) begin
            if (qen[q] && db_addr[63:PAGE_LSB] == bell_pg[q]) begin
                sel     = QW'(q);
                any_hit = 1'b1;
            end
        end
    end

    always_comb begin
        drop = '0;
        load = 1'b0;
        if (db_valid && db_ready && any_hit) begin
            if (full[sel]) drop[sel] = 1'b1;
            else           load      = 1'b1;
        end
        load_addr = {ring_pg[sel], 12'({tail_arr[sel], 2'b00})};
    end

    evq_stage #(.QW(QW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (load_addr),
        .load_data ({16'h0000, db_data}),
        .load_q    (sel),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .done      (done),
        .done_q    (done_q)
    );

    assign db_ready = !mem_valid;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == GEN_ADDR) begin
            reg_rdata = 32'(gen_en);
        end else begin
            for (int q = 0; q < NQ; q++)
                if (int'(reg_addr[RAW-1:3]) == q) reg_rdata = rd_word[q];
        end
    end
endmodule

// File: rtl/evq_chk.sv
module evq_chk #(
    parameter int NQ    = 4,
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             db_ready,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [63:0]      mem_addr,
    input logic [31:0]      mem_data,
    input logic [NQ-1:0]    irq,
    input logic [NQ-1:0]    gen_en,
    input logic [PTR_W-1:0] tail_arr [NQ]
);
    a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    a_r2_busy_blocks_bell: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !db_ready);

    a_r1_upper_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_data[31:16] == 16'h0000);

    for (genvar g = 0; g < NQ; g++) begin : g_q
        a_r2_tail_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
            !(mem_valid && mem_ready) |=> $stable(tail_arr[g]));

        a_r4_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> gen_en[g]);
    end
endmodule

bind msi_evq_ctrl evq_chk #(.NQ(NQ), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_ready  (db_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .irq       (irq),
    .gen_en    (gen_en),
    .tail_arr  (tail_arr)
);

// File: tb/sim_msi_evq_ctrl.sv
module sim_msi_evq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NQ    = 2;
    localparam int DEPTH = 64;
    localparam int RAW   = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic reg_wr = 0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic db_valid = 0;
    logic [63:0] db_addr = '0;
    logic [15:0] db_data = '0;
    logic db_ready, mem_valid, mem_ready = 1'b1;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;
    logic [NQ-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_evq_ctrl #(.NQ(NQ), .PTR_W(6), .HAS_GLOBAL_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
        .db_addr(db_addr), .db_data(db_data), .db_ready(db_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready), .irq(irq));

    // behavioural reference model
    longint unsigned m_ring [NQ];
    longint unsigned m_bell [NQ];
    bit m_qen [NQ], m_evt [NQ], m_ien [NQ], m_ovf [NQ];
    int m_head [NQ], m_tail [NQ];
    bit [NQ-1:0] m_gen;
    bit m_v;
    longint unsigned m_addr;
    int unsigned m_data;
    int m_q;

    always @(posedge clk) begin
        bit done_now, ld, dr;
        int hq, qi, w;
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                m_ring[q] = 0; m_bell[q] = 0; m_qen[q] = 0; m_evt[q] = 0;
                m_ien[q] = 0; m_ovf[q] = 0; m_head[q] = 0; m_tail[q] = 0;
            end
            m_gen = 0; m_v = 0; m_addr = 0; m_data = 0; m_q = 0;
        end else begin
            done_now = m_v && mem_ready;
            ld = 0; dr = 0; hq = -1;
            if (!m_v && db_valid)
                for (int q = 0; q < NQ; q++)
                    if (hq < 0 && m_qen[q] && (db_addr >> 12) == (m_bell[q] >> 12)) hq = q;
            if (hq >= 0) begin
                if (((m_tail[hq] + 1) % DEPTH) == m_head[hq]) dr = 1;
                else ld = 1;
            end
            if (reg_wr) begin
                qi = int'(reg_addr) / 8;
                w  = int'(reg_addr) % 8;
                if (int'(reg_addr) == NQ * 8) m_gen = reg_wdata[NQ-1:0];
                else if (qi < NQ) begin
                    case (w)
                        0: m_ring[qi] = (m_ring[qi] & 64'hFFFF_FFFF_0000_0000) | longint'(reg_wdata & 32'hFFFF_F000);
                        1: m_ring[qi] = (m_ring[qi] & 64'h0000_0000_FFFF_FFFF) | (longint'(reg_wdata) << 32);
                        2: m_bell[qi] = (m_bell[qi] & 64'hFFFF_FFFF_0000_0000) | longint'(reg_wdata & 32'hFFFF_F000);
                        3: m_bell[qi] = (m_bell[qi] & 64'h0000_0000_FFFF_FFFF) | (longint'(reg_wdata) << 32);
                        4: begin m_qen[qi] = reg_wdata[0]; m_evt[qi] = reg_wdata[1]; m_ien[qi] = reg_wdata[11]; end
                        5: m_head[qi] = int'(reg_wdata % DEPTH);
                        7: if (reg_wdata[0]) m_ovf[qi] = 0;
                        default: ;
                    endcase
                end
            end
            if (done_now) begin m_tail[m_q] = (m_tail[m_q] + 1) % DEPTH; m_v = 0; end
            if (dr) m_ovf[hq] = 1;
            if (ld) begin
                m_v = 1; m_q = hq;
                m_addr = m_ring[hq] + longint'(m_tail[hq] * 4);
                m_data = {16'h0000, db_data};
            end
        end
    end

    task automatic chk(input string tag, input longint unsigned got, input longint unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // per-cycle comparison of registered outputs
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int q = 0; q < NQ; q++)
                chk("R4 irq", irq[q],
                    longint'(m_qen[q] && m_evt[q] && m_ien[q] && m_gen[q] && m_head[q] != m_tail[q]));
            chk("R2 db_ready", db_ready, longint'(!m_v));
            chk("R2 mem_valid", mem_valid, longint'(m_v));
            if (m_v) begin
                chk("R1 mem_addr", mem_addr, m_addr);
                chk("R1 mem_data", mem_data, m_data);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = RAW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = RAW'(a);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic ring(input logic [63:0] a, input logic [15:0] d);
        @(negedge clk);
        while (m_v) @(negedge clk);
        db_valid = 1; db_addr = a; db_data = d;
        @(negedge clk);
        db_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R8: reset values
        rd(6, 0, "R8 reset tail q0");
        rd(12, 0, "R8 reset ctrl q1");
        rd(16, 0, "R8 reset global");
        // R7: page programming
        wr(0, 32'h2345_6ABC);
        rd(0, 32'h2345_6000, "R7 ring lo page bits");
        wr(1, 32'h0000_0001);
        rd(1, 32'h0000_0001, "R7 ring hi");
        wr(2, 32'hFEE0_0123); wr(3, 0);
        rd(2, 32'hFEE0_0000, "R7 bell lo page bits");
        wr(8, 32'h0008_0000); wr(9, 0);
        wr(10, 32'hFEE0_1000); wr(11, 0);
        wr(4, 32'h803); wr(12, 32'h803);
        rd(4, 32'h803, "R8 ctrl readback");
        wr(16, 3);
        rd(16, 3, "R8 global readback");
        // R1: arbitrary data queued
        ring(64'h0000_0000_FEE0_0014, 16'h0005);
        ring(64'h0000_0000_FEE0_0ABC, 16'hBEEF);
        idle(2);
        rd(6, 2, "R2 tail after two");
        // R4: each gate
        wr(16, 2); idle(1);
        wr(16, 3); idle(1);
        wr(4, 32'h801); idle(1);
        wr(4, 32'h003); idle(1);
        wr(4, 32'h802); idle(1);
        wr(4, 32'h803); idle(1);
        // R5: drain
        wr(5, 1); idle(1);
        wr(5, 2); idle(1);
        rd(5, 2, "R5 head readback");
        // R2: stall, doorbell while busy ignored
        mem_ready = 0;
        ring(64'h0000_0000_FEE0_1000, 16'h1234);
        @(negedge clk);
        db_valid = 1; db_addr = 64'h0000_0000_FEE0_0000; db_data = 16'h7777;
        @(negedge clk);
        db_valid = 0;
        idle(3);
        rd(6, 2, "R2 busy doorbell ignored");
        mem_ready = 1;
        idle(2);
        rd(14, 1, "R2 q1 tail after stall");
        // R6: unmatched and disabled
        ring(64'h0000_0000_FEE0_2000, 16'h0001);
        ring(64'h0000_0001_FEE0_0000, 16'h0002);
        wr(12, 32'h802);
        ring(64'h0000_0000_FEE0_1000, 16'h0003);
        idle(2);
        rd(6, 2, "R6 q0 tail unchanged");
        rd(14, 1, "R6 q1 tail unchanged");
        wr(12, 32'h803);
        // R3: fill q1 then overflow
        for (int i = 0; i < 62; i++) ring(64'h0000_0000_FEE0_1000 | 64'(i * 4), 16'(i + 16'h100));
        idle(2);
        rd(14, 63, "R3 q1 tail full");
        ring(64'h0000_0000_FEE0_1000, 16'hDEAD);
        idle(2);
        rd(14, 63, "R3 tail unchanged on drop");
        rd(15, 1, "R3 overflow set");
        idle(2);
        rd(15, 1, "R3 overflow sticky");
        wr(15, 1);
        rd(15, 0, "R3 overflow cleared");
        // R2 wrap
        wr(13, 63); idle(1);
        ring(64'h0000_0000_FEE0_1000, 16'hA5A5);
        idle(2);
        rd(14, 0, "R2 tail wraps to 0");
        ring(64'h0000_0000_FEE0_1004, 16'h5A5A);
        idle(2);
        rd(14, 1, "R2 tail after wrap");
        idle(3);
        summary();
    end
endmodule